// File: doc/BRIEF.md
# Fully Associative Address Translation Cache with Address-Space Tags

This block caches recent virtual-to-physical page translations. A requester presents a virtual address, an address-space identifier and an access kind (read, write or instruction fetch). One cycle later the block returns a registered response. The response carries a physical address and one of two flags, hit or miss. It also carries a protection-fault flag and the usage flags that the matching entry held before this lookup.

Any entry can hold any translation. Every valid entry is compared against the request at once, so placement never limits what the cache can hold. Pages are 4 KB: the low 12 address bits pass through unchanged and only the page number is translated. A miss handler outside the block, in hardware or software, walks the page table and installs the result through the fill port. Operating-system code drops stale mappings through the invalidate inputs, either all of them or those of one address space. A lookup that hits keeps the entry's usage flags up to date. These flags are used by page replacement and by the write-back of modified pages.

Top module: `xlat_cache`

## Requirements
- R1: A request hits when a valid entry holds the same virtual page number (address bits 31..12) and the same address-space identifier. Any entry position can hold any translation. When it hits, the response gives the entry's frame number in bits 31..12 of the physical address.
- R2: On a hit, physical address bits 11..0 equal virtual address bits 11..0 of the request.
- R3: When no valid entry matches both page number and identifier, the response flags a miss and the physical address is zero. This includes a matching page number under a different identifier.
- R4: The response valid output is high exactly one cycle after each cycle in which the request valid input is high. While the response valid output is low, the hit, miss and fault outputs stay low.
- R5: Every hit sets the entry's referenced flag. A permitted write hit also sets its dirty flag. The response reports both flags as they stood before this lookup. Kind encoding: 0 read, 1 write, 2 fetch; 3 behaves as read.
- R6: A write (kind 1) that hits an entry installed as read-only reports both hit and fault and leaves the dirty flag clear. Reads and fetches to read-only entries do not fault.
- R7: A fill writes the lowest-numbered invalid entry. When every entry is valid, a fill replaces the entry at a round-robin pointer. The pointer starts at 0 and advances by one, wrapping, after each such replacement. A filled entry starts with its dirty and referenced flags clear.
- R8: Invalidate-all clears every entry in a single cycle.
- R9: Invalidate-by-identifier clears only the entries whose identifier equals the given value.
- R10: In a cycle that also has an invalidate, a fill is dropped. When a fill and a lookup hit touch the same entry in one cycle, the fill's cleared flags win.
- R11: After reset, all entries are invalid, the round-robin pointer is 0 and no response is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_asid | input | ASID_W | Address-space identifier of the request |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | VA_W-OFF_W | Virtual page number to install |
| fill_pfn | input | PA_W-OFF_W | Physical frame number to install |
| fill_asid | input | ASID_W | Identifier of the installed translation |
| fill_writable | input | 1 | 1 = read/write, 0 = read-only |
| inv_all | input | 1 | Clear every entry |
| inv_asid_en | input | 1 | Clear entries whose identifier matches inv_asid |
| inv_asid | input | ASID_W | Identifier to clear |
| rsp_valid | output | 1 | Registered response present |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | No translation found |
| rsp_fault | output | 1 | Write to a read-only page |
| rsp_paddr | output | PA_W | Translated address, zero on miss |
| rsp_was_dirty | output | 1 | Entry's dirty flag before this lookup |
| rsp_was_ref | output | 1 | Entry's referenced flag before this lookup |

## Verification
The assertions assume that the fill source never installs two live entries with the same page number and identifier, so at most one entry can match. The stimulus honours this: each page number it installs is unique, or it is installed only after the previous copy has been evicted or invalidated. Beyond that, the inputs are left unconstrained. Lookups, fills and invalidates may fall in the same cycle, which exercises the priority rules. A behavioural model in the bench reproduces the hit, fault and flag results every cycle.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_e;

   function automatic logic is_store(input logic [1:0] kind);
      return kind == ACC_WRITE;
   endfunction
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
   parameter int N      = 8,
   parameter int VPN_W  = 20,
   parameter int ASID_W = 8
) (
   input  logic [N-1:0]             vld,
   input  logic [N-1:0][VPN_W-1:0]  tag_vpn,
   input  logic [N-1:0][ASID_W-1:0] tag_asid,
   input  logic [VPN_W-1:0]         key_vpn,
   input  logic [ASID_W-1:0]        key_asid,
   output logic [N-1:0]             match
);
   for (genvar g = 0; g < N; g++) begin : g_cmp
      assign match[g] = vld[g] && (tag_vpn[g] == key_vpn) && (tag_asid[g] == key_asid);
   end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     vld,
   input  logic             fill_go,
   output logic [IDX_W-1:0] pick
);
   logic [IDX_W-1:0] rr_q;
   logic             free_found;

   always_comb begin
      pick       = rr_q;
      free_found = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (!vld[i] && !free_found) begin
            pick       = IDX_W'(i);
            free_found = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rr_q <= '0;
      end else if (fill_go && (&vld)) begin
         rr_q <= (rr_q == IDX_W'(N-1)) ? '0 : rr_q + 1'b1;
      end
   end

   // R7: a free slot is always preferred over eviction
   a_r7_pick_free: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_go && !(&vld)) |-> !vld[pick]);
   // R7: a replacement with a full array steps the pointer by one
   a_r7_rr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_go && (&vld)) |=> (rr_q != $past(rr_q)));
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
   import xlat_pkg::*;
#(
   parameter int VA_W   = 32,
   parameter int PA_W   = 32,
   parameter int OFF_W  = 12,
   parameter int N      = 8,
   parameter int ASID_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic [VA_W-1:0]       req_vaddr,
   input  logic [ASID_W-1:0]     req_asid,
   input  logic [1:0]            req_kind,
   input  logic                  fill_en,
   input  logic [VA_W-OFF_W-1:0] fill_vpn,
   input  logic [PA_W-OFF_W-1:0] fill_pfn,
   input  logic [ASID_W-1:0]     fill_asid,
   input  logic                  fill_writable,
   input  logic                  inv_all,
   input  logic                  inv_asid_en,
   input  logic [ASID_W-1:0]     inv_asid,
   output logic                  rsp_valid,
   output logic                  rsp_hit,
   output logic                  rsp_miss,
   output logic                  rsp_fault,
   output logic [PA_W-1:0]       rsp_paddr,
   output logic                  rsp_was_dirty,
   output logic                  rsp_was_ref
);
   localparam int VPN_W = VA_W - OFF_W;
   localparam int PFN_W = PA_W - OFF_W;
   localparam int IDX_W = $clog2(N);

   if (OFF_W >= VA_W || OFF_W >= PA_W) begin : g_bad_off
      $error("xlat_cache: page offset must be narrower than both addresses");
   end
   if (N < 2) begin : g_bad_n
      $error("xlat_cache: at least two entries are required");
   end

   logic [N-1:0]             vld_q, wr_q, dirty_q, ref_q;
   logic [N-1:0][VPN_W-1:0]  vpn_q;
   logic [N-1:0][PFN_W-1:0]  pfn_q;
   logic [N-1:0][ASID_W-1:0] asid_q;

   logic [N-1:0]     match;
   logic             hit_any;
   logic [IDX_W-1:0] hit_idx;
   logic [IDX_W-1:0] victim;
   logic             fill_go;
   logic             store;
   logic             look_hit;

   xlat_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_match (
      .vld      (vld_q),
      .tag_vpn  (vpn_q),
      .tag_asid (asid_q),
      .key_vpn  (req_vaddr[VA_W-1:OFF_W]),
      .key_asid (req_asid),
      .match    (match)
   );

   always_comb begin
      hit_idx = '0;
      for (int i = N-1; i >= 0; i--) begin
         if (match[i]) hit_idx = IDX_W'(i);
      end
   end

   assign hit_any  = |match;
   assign store    = is_store(req_kind);
   assign look_hit = req_valid && hit_any;
   assign fill_go  = fill_en && !inv_all && !inv_asid_en;

   xlat_victim #(.N(N), .IDX_W(IDX_W)) u_victim (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld     (vld_q),
      .fill_go (fill_go),
      .pick    (victim)
   );

   // response register
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         rsp_hit       <= 1'b0;
         rsp_miss      <= 1'b0;
         rsp_fault     <= 1'b0;
         rsp_paddr     <= '0;
         rsp_was_dirty <= 1'b0;
         rsp_was_ref   <= 1'b0;
      end else begin
         rsp_valid     <= req_valid;
         rsp_hit       <= look_hit;
         rsp_miss      <= req_valid && !hit_any;
         rsp_fault     <= look_hit && store && !wr_q[hit_idx];
         rsp_paddr     <= look_hit ? {pfn_q[hit_idx], req_vaddr[OFF_W-1:0]} : '0;
         rsp_was_dirty <= look_hit && dirty_q[hit_idx];
         rsp_was_ref   <= look_hit && ref_q[hit_idx];
      end
   end

   // entry state: lookup flags first, then invalidate / fill take precedence
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q   <= '0;
         dirty_q <= '0;
         ref_q   <= '0;
      end else begin
         if (look_hit) begin
            ref_q[hit_idx] <= 1'b1;
            if (store && wr_q[hit_idx]) dirty_q[hit_idx] <= 1'b1;
         end
         if (inv_all) begin
            vld_q <= '0;
         end else if (inv_asid_en) begin
            for (int i = 0; i < N; i++) begin
               if (asid_q[i] == inv_asid) vld_q[i] <= 1'b0;
            end
         end else if (fill_en) begin
            vld_q[victim]   <= 1'b1;
            ref_q[victim]   <= 1'b0;
            dirty_q[victim] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (fill_go) begin
         vpn_q[victim]  <= fill_vpn;
         pfn_q[victim]  <= fill_pfn;
         asid_q[victim] <= fill_asid;
         wr_q[victim]   <= fill_writable;
      end
   end

   // R1: the fill source keeps keys unique, so at most one entry matches
   a_r1_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));
   a_r1_hit_xor_miss: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_hit != rsp_miss));
   a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> (rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));
   a_r3_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_miss |-> (rsp_paddr == '0));
   a_r4_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   a_r4_quiet_flags: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault));
   a_r6_fault_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> rsp_hit);
   a_r8_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
      inv_all |=> (vld_q == '0));
   a_r10_fill_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_all || inv_asid_en) |=> ($countones(vld_q) <= $countones($past(vld_q))));
endmodule

// File: tb/tb_xlat_cache.sv
`timescale 1ns/1ps
module tb_xlat_cache;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic [7:0]  req_asid = '0;
   logic [1:0]  req_kind = '0;
   logic        fill_en = 1'b0;
   logic [19:0] fill_vpn = '0;
   logic [19:0] fill_pfn = '0;
   logic [7:0]  fill_asid = '0;
   logic        fill_writable = 1'b0;
   logic        inv_all = 1'b0;
   logic        inv_asid_en = 1'b0;
   logic [7:0]  inv_asid = '0;
   logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_was_dirty, rsp_was_ref;
   logic [31:0] rsp_paddr;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   xlat_cache dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
      .req_asid(req_asid), .req_kind(req_kind), .fill_en(fill_en), .fill_vpn(fill_vpn),
      .fill_pfn(fill_pfn), .fill_asid(fill_asid), .fill_writable(fill_writable),
      .inv_all(inv_all), .inv_asid_en(inv_asid_en), .inv_asid(inv_asid),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
      .rsp_paddr(rsp_paddr), .rsp_was_dirty(rsp_was_dirty), .rsp_was_ref(rsp_was_ref)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   bit        m_vld[8], m_wr[8], m_d[8], m_r[8];
   bit [19:0] m_vpn[8], m_pfn[8];
   bit [7:0]  m_asid[8];
   int        m_rr;
   bit        e_valid, e_hit, e_miss, e_fault, e_wd, e_wref;
   bit [31:0] e_pa;

   always @(posedge clk) begin : model
      int hi;
      int v;
      if (!rst_n) begin
         for (int i = 0; i < 8; i++) m_vld[i] = 0;
         m_rr = 0;
         {e_valid, e_hit, e_miss, e_fault, e_wd, e_wref} = '0;
         e_pa = '0;
      end else begin
         hi = -1;
         for (int i = 0; i < 8; i++)
            if (hi < 0 && m_vld[i] && m_vpn[i] == req_vaddr[31:12] && m_asid[i] == req_asid) hi = i;
         e_valid = req_valid;
         e_hit   = req_valid && hi >= 0;
         e_miss  = req_valid && hi < 0;
         e_fault = 0; e_wd = 0; e_wref = 0; e_pa = '0;
         if (e_hit) begin
            e_pa    = {m_pfn[hi], req_vaddr[11:0]};
            e_fault = (req_kind == 2'd1) && !m_wr[hi];
            e_wd    = m_d[hi];
            e_wref  = m_r[hi];
            m_r[hi] = 1;
            if (req_kind == 2'd1 && m_wr[hi]) m_d[hi] = 1;
         end
         if (inv_all) begin
            for (int i = 0; i < 8; i++) m_vld[i] = 0;
         end else if (inv_asid_en) begin
            for (int i = 0; i < 8; i++) if (m_asid[i] == inv_asid) m_vld[i] = 0;
         end else if (fill_en) begin
            v = -1;
            for (int i = 0; i < 8; i++) if (v < 0 && !m_vld[i]) v = i;
            if (v < 0) begin
               v = m_rr;
               m_rr = (m_rr + 1) % 8;
            end
            m_vld[v] = 1; m_vpn[v] = fill_vpn; m_pfn[v] = fill_pfn;
            m_asid[v] = fill_asid; m_wr[v] = fill_writable; m_d[v] = 0; m_r[v] = 0;
         end
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         chk(rsp_valid == e_valid, "R4 valid", 32'(rsp_valid), 32'(e_valid));
         chk(rsp_hit == e_hit && rsp_miss == e_miss, "R1 hit/miss",
             {30'd0, rsp_hit, rsp_miss}, {30'd0, e_hit, e_miss});
         chk(rsp_paddr == e_pa, "R2 paddr", rsp_paddr, e_pa);
         chk(rsp_fault == e_fault, "R6 fault", 32'(rsp_fault), 32'(e_fault));
         chk(rsp_was_dirty == e_wd && rsp_was_ref == e_wref, "R5 flags",
             {30'd0, rsp_was_dirty, rsp_was_ref}, {30'd0, e_wd, e_wref});
      end
   end

   task automatic look(input logic [31:0] va, input logic [7:0] asid, input logic [1:0] kind);
      @(negedge clk);
      req_valid = 1; req_vaddr = va; req_asid = asid; req_kind = kind;
      @(negedge clk);
      req_valid = 0;
   endtask

   task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn, input logic [7:0] asid,
                       input logic wr);
      @(negedge clk);
      fill_en = 1; fill_vpn = vpn; fill_pfn = pfn; fill_asid = asid; fill_writable = wr;
      @(negedge clk);
      fill_en = 0;
   endtask

   task automatic finish_run;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(rsp_valid == 0, "R11 reset valid", 32'(rsp_valid), 0);
      rst_n = 1;
      look(32'h1234_5678, 8'd1, 2'd0);
      chk(rsp_miss == 1, "R11 empty after reset", 32'(rsp_miss), 1);

      fill(20'h12345, 20'hABCDE, 8'd1, 1'b1);
      fill(20'h00040, 20'h00010, 8'd0, 1'b0);
      fill(20'h00041, 20'h00011, 8'd0, 1'b0);

      look(32'h1234_5678, 8'd1, 2'd0);
      chk(rsp_hit == 1, "R1 hit", 32'(rsp_hit), 1);
      chk(rsp_paddr == 32'hABCD_E678, "R2 translated", rsp_paddr, 32'hABCD_E678);
      chk(rsp_was_ref == 0, "R5 first touch", 32'(rsp_was_ref), 0);
      look(32'h1234_5000, 8'd1, 2'd0);
      chk(rsp_was_ref == 1, "R5 ref set", 32'(rsp_was_ref), 1);
      look(32'h1234_5004, 8'd1, 2'd1);
      chk(rsp_was_dirty == 0 && rsp_fault == 0, "R5 first write", 32'(rsp_was_dirty), 0);
      look(32'h1234_5008, 8'd1, 2'd1);
      chk(rsp_was_dirty == 1, "R5 dirty set", 32'(rsp_was_dirty), 1);
      look(32'h1234_5678, 8'd2, 2'd0);
      chk(rsp_miss == 1 && rsp_paddr == 0, "R3 asid mismatch", rsp_paddr, 0);

      look(32'h0004_0ABC, 8'd0, 2'd1);
      chk(rsp_fault == 1 && rsp_hit == 1, "R6 ro write", 32'(rsp_fault), 1);
      look(32'h0004_0ABC, 8'd0, 2'd1);
      chk(rsp_was_dirty == 0, "R6 dirty untouched", 32'(rsp_was_dirty), 0);
      look(32'h0004_0ABC, 8'd0, 2'd2);
      chk(rsp_fault == 0 && rsp_hit == 1, "R6 ro fetch", 32'(rsp_fault), 0);

      for (int k = 0; k < 5; k++) fill(20'h00050 + 20'(k), 20'h00100 + 20'(k), 8'd1, 1'b1);
      fill(20'h00060, 20'h00200, 8'd1, 1'b1);
      look(32'h1234_5000, 8'd1, 2'd0);
      chk(rsp_miss == 1, "R7 entry0 evicted", 32'(rsp_miss), 1);
      look(32'h0006_0010, 8'd1, 2'd0);
      chk(rsp_paddr == 32'h0020_0010, "R7 new entry", rsp_paddr, 32'h0020_0010);
      fill(20'h00061, 20'h00201, 8'd1, 1'b1);
      look(32'h0004_0000, 8'd0, 2'd0);
      chk(rsp_miss == 1, "R7 entry1 evicted", 32'(rsp_miss), 1);
      look(32'h0004_1000, 8'd0, 2'd0);
      chk(rsp_hit == 1, "R7 entry2 kept", 32'(rsp_hit), 1);

      @(negedge clk); inv_asid_en = 1; inv_asid = 8'd0;
      @(negedge clk); inv_asid_en = 0;
      look(32'h0004_1000, 8'd0, 2'd0);
      chk(rsp_miss == 1, "R9 asid0 cleared", 32'(rsp_miss), 1);
      look(32'h0005_0000, 8'd1, 2'd0);
      chk(rsp_hit == 1, "R9 asid1 kept", 32'(rsp_hit), 1);

      @(negedge clk);
      inv_all = 1; fill_en = 1; fill_vpn = 20'h00070; fill_pfn = 20'h00300;
      fill_asid = 8'd1; fill_writable = 1;
      @(negedge clk); inv_all = 0; fill_en = 0;
      look(32'h0007_0000, 8'd1, 2'd0);
      chk(rsp_miss == 1, "R10 fill dropped", 32'(rsp_miss), 1);
      look(32'h0005_0000, 8'd1, 2'd0);
      chk(rsp_miss == 1, "R8 all cleared", 32'(rsp_miss), 1);

      // mixed traffic, checked every cycle against the model
      for (int c = 0; c < 400; c++) begin
         @(negedge clk);
         req_valid = ($urandom % 4) != 0;
         req_vaddr = {12'h000, 8'h00 + 8'($urandom % 24), 12'($urandom)};
         req_vaddr[31:12] = 20'h00200 + 20'($urandom % 24);
         req_asid  = 8'($urandom % 3);
         req_kind  = 2'($urandom);
         fill_en   = (c % 3) == 0 && c < 300;
         fill_vpn  = 20'h00200 + 20'(c / 3 % 100 < 24 ? c / 3 : 0);
         fill_en   = fill_en && (c / 3) < 24;
         fill_pfn  = 20'($urandom);
         fill_asid = 8'((c / 3) % 3);
         fill_writable = $urandom % 2;
         inv_asid_en = (c % 97) == 50;
         inv_asid  = 8'($urandom % 3);
      end
      @(negedge clk);
      req_valid = 0; fill_en = 0; inv_asid_en = 0;
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule